// File: doc/BRIEF.md
# Cyclic Prefix Inserter with Edge Taper

This block sits between the inverse transform and the digital front end of a multicarrier transmitter. It takes one complex time-domain symbol of `SYM_LEN` samples in natural order. It sends out a guard prefix, which is a copy of the symbol's last `CP_LEN` samples, and then the whole symbol. The first `OVL_LEN` prefix samples are cross-faded against a four-entry cache that holds the final samples of the data symbol sent before. This makes the power taper off at the join between symbols instead of stepping.

Two sample banks are used in turn. While one bank is read out, the next symbol is written into the other. A per-symbol mode flag marks a synchronisation symbol that already carries its own guard and shaping. Such a symbol is stored and sent out unchanged, with no prefix and no blending, and it clears the taper cache, so the first data symbol after it fades in from zero. Each symbol takes `SYM_LEN + CP_LEN + 1` output cycles, so on average the source must leave at least `CP_LEN + 1` idle cycles per symbol. A sample that arrives while its target bank is still waiting to be read is discarded.

Top module: `cpwin_inserter`

## Requirements
- R1: After reset, `out_valid_o` is low and both output components are zero. No output appears until a full symbol has been written.
- R2: A data symbol (`in_bypass_i` low on its first sample) of 256 accepted samples is sent out as 272 samples. First come input samples 240..255 in that order (the prefix), then samples 0..255 in order.
- R3: All outputs of one symbol come on consecutive clock cycles.
- R4: Prefix position k, for k = 0..3, is floor((x·r + t·(32768 − r)) / 32768), computed per component, where x is input sample 240+k, r = (k+1)·8192, and t is sample 252+k of the previous data symbol. Prefix positions 4..15 and all body samples are not modified.
- R5: The taper cache is zero after reset and after a bypass symbol. The first data symbol that follows either of these blends against zero.
- R6: A bypass symbol (`in_bypass_i` high on its first accepted sample) is sent out as its 256 samples in input order, with no prefix and no blending.
- R7: `in_bypass_i` is sampled only with the first accepted sample of a symbol. Changing it on later samples has no effect on that symbol.
- R8: Input samples count only on cycles where `in_valid_i` is high. Idle cycles of any length inside a symbol do not change the output.
- R9: A symbol can be written into one bank while the other bank is being read. When the reader is idle, the first output comes on the third rising edge after the edge that accepted the last input sample. Two queued symbols are sent with exactly one idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample present |
| in_bypass_i | input | 1 | Symbol mode, taken with the first sample: 1 = pass unchanged |
| in_re_i | input | 16 | Input real part, two's complement |
| in_im_i | input | 16 | Input imaginary part, two's complement |
| out_valid_o | output | 1 | Output sample present |
| out_re_o | output | 16 | Output real part, two's complement |
| out_im_o | output | 16 | Output imaginary part, two's complement |

## Verification
Ramp-like symbols with different seeds make every prefix and body position distinct, so a wrong read address or wrong order shows up at once. Constant full-scale negative and positive symbols, followed by an alternating-sign symbol, drive the taper to its numeric limits and check floor rounding on negative sums. A bypass symbol, and symbols whose mode flag toggles after the first sample, separate per-symbol mode capture from per-sample mode use and show whether the cache is cleared. Sparse input (one idle cycle before each sample) and back-to-back symbols with no gap separate sample counting from cycle counting, and check the hand-off between the two banks.

// File: rtl/cpwin_pkg.sv
package cpwin_pkg;

  typedef enum logic [1:0] {
    RD_IDLE   = 2'd0,
    RD_PREFIX = 2'd1,
    RD_BODY   = 2'd2
  } rd_state_e;

  // rising taper weight for overlap slot k, fb fractional bits
  function automatic int rise_coef(input int k, input int ovl, input int fb);
    return ((k + 1) << fb) / ovl;
  endfunction

endpackage

// File: rtl/cpwin_bank.sv
module cpwin_bank #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);

  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end

endmodule

// File: rtl/cpwin_taper.sv
module cpwin_taper #(
  parameter int DW      = 16,
  parameter int OVL_LEN = 4,
  localparam int OW = (OVL_LEN > 1) ? $clog2(OVL_LEN) : 1,
  localparam int FB = DW - 1,
  localparam int CW = DW + 2,
  localparam int PW = DW + CW + 1
) (
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] t_i,
  input  logic                 en_i,
  input  logic [OW-1:0]        idx_i,
  output logic signed [DW-1:0] y_o
);

  logic signed [CW-1:0] c_rise, c_fall;
  logic signed [PW-1:0] acc;

  always_comb begin
    c_rise = CW'(cpwin_pkg::rise_coef(int'(idx_i), OVL_LEN, FB));
    c_fall = CW'(1 << FB) - c_rise;
    acc    = PW'(x_i) * PW'(c_rise) + PW'(t_i) * PW'(c_fall);
    // weights sum to unity, so the shifted sum always fits DW
    y_o    = en_i ? DW'(acc >>> FB) : x_i;
  end

endmodule

// File: rtl/cpwin_reader.sv
module cpwin_reader
  import cpwin_pkg::*;
#(
  parameter int SYM_LEN = 256,
  parameter int CP_LEN  = 16,
  parameter int OVL_LEN = 4,
  localparam int AW = $clog2(SYM_LEN),
  localparam int OW = (OVL_LEN > 1) ? $clog2(OVL_LEN) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    full_i,
  input  logic [1:0]    byp_i,
  output logic          rd_en_o,
  output logic          rd_sel_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          done_o,
  output logic          blend_o,
  output logic [OW-1:0] blend_idx_o,
  output logic          cap_o,
  output logic [OW-1:0] cap_idx_o,
  output logic          clr_o
);

  localparam logic [AW-1:0] CP_LAST   = AW'(CP_LEN - 1);
  localparam logic [AW-1:0] SYM_LAST  = AW'(SYM_LEN - 1);
  localparam logic [AW-1:0] PRE_BASE  = AW'(SYM_LEN - CP_LEN);
  localparam logic [AW-1:0] TAIL_BASE = AW'(SYM_LEN - OVL_LEN);
  localparam logic [AW-1:0] OVL_N     = AW'(OVL_LEN);

  rd_state_e     state_q;
  logic [AW-1:0] cnt_q;
  logic          sel_q;
  logic          byp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RD_IDLE;
      cnt_q   <= '0;
      sel_q   <= 1'b0;
      byp_q   <= 1'b0;
    end else begin
      case (state_q)
        RD_IDLE: begin
          if (full_i[sel_q]) begin
            byp_q   <= byp_i[sel_q];
            cnt_q   <= '0;
            state_q <= byp_i[sel_q] ? RD_BODY : RD_PREFIX;
          end
        end
        RD_PREFIX: begin
          if (cnt_q == CP_LAST) begin
            cnt_q   <= '0;
            state_q <= RD_BODY;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RD_BODY: begin
          if (cnt_q == SYM_LAST) begin
            cnt_q   <= '0;
            state_q <= RD_IDLE;
            sel_q   <= ~sel_q;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_en_o     = (state_q != RD_IDLE);
    rd_sel_o    = sel_q;
    rd_addr_o   = (state_q == RD_PREFIX) ? PRE_BASE + cnt_q : cnt_q;
    done_o      = (state_q == RD_BODY) && (cnt_q == SYM_LAST);
    blend_o     = (state_q == RD_PREFIX) && (cnt_q < OVL_N);
    blend_idx_o = OW'(cnt_q);
    cap_o       = (state_q == RD_BODY) && !byp_q && (cnt_q >= TAIL_BASE);
    cap_idx_o   = OW'(cnt_q - TAIL_BASE);
    clr_o       = (state_q == RD_BODY) && byp_q && (cnt_q == SYM_LAST);
  end

  // R9: reader only walks a bank the writer has marked complete
  p_src_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> full_i[sel_q]);

  // R7: mode captured at symbol start holds for the whole symbol
  p_mode_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != RD_IDLE) |=> (state_q == RD_IDLE) || $stable(byp_q));

  // R2: last prefix sample is followed by body address zero
  p_prefix_to_body_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RD_PREFIX && cnt_q == CP_LAST) |=> (state_q == RD_BODY && rd_addr_o == '0));

endmodule

// File: rtl/cpwin_inserter.sv
module cpwin_inserter
  import cpwin_pkg::*;
#(
  parameter int DW      = 16,
  parameter int SYM_LEN = 256,
  parameter int CP_LEN  = 16,
  parameter int OVL_LEN = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic          in_bypass_i,
  input  logic [DW-1:0] in_re_i,
  input  logic [DW-1:0] in_im_i,
  output logic          out_valid_o,
  output logic [DW-1:0] out_re_o,
  output logic [DW-1:0] out_im_o
);

  localparam int AW = $clog2(SYM_LEN);
  localparam int OW = (OVL_LEN > 1) ? $clog2(OVL_LEN) : 1;
  localparam int SW = 2 * DW;

  // ---------------- writer ----------------
  logic          wr_sel_q;
  logic [AW-1:0] wr_cnt_q;
  logic [1:0]    full_q;
  logic [1:0]    byp_q;
  logic          wr_acc, wr_last;

  logic          rd_en, rd_sel, rd_done;
  logic [AW-1:0] rd_addr;
  logic          rd_blend, rd_cap, rd_clr;
  logic [OW-1:0] rd_bidx, rd_cidx;

  assign wr_acc  = in_valid_i && !full_q[wr_sel_q];
  assign wr_last = (wr_cnt_q == AW'(SYM_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_sel_q <= 1'b0;
      wr_cnt_q <= '0;
      full_q   <= '0;
      byp_q    <= '0;
    end else begin
      if (wr_acc) begin
        wr_cnt_q <= wr_last ? '0 : wr_cnt_q + 1'b1;
        if (wr_cnt_q == '0) byp_q[wr_sel_q] <= in_bypass_i;
        if (wr_last) wr_sel_q <= ~wr_sel_q;
      end
      for (int b = 0; b < 2; b++) begin
        if (wr_acc && wr_last && (wr_sel_q == 1'(b))) full_q[b] <= 1'b1;
        else if (rd_done && (rd_sel == 1'(b)))        full_q[b] <= 1'b0;
      end
    end
  end

  // ---------------- sample banks ----------------
  logic [SW-1:0] bank_rd [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    cpwin_bank #(.WIDTH(SW), .DEPTH(SYM_LEN)) u_bank (
      .clk_i   (clk_i),
      .we_i    (wr_acc && (wr_sel_q == 1'(b))),
      .waddr_i (wr_cnt_q),
      .wdata_i ({in_re_i, in_im_i}),
      .raddr_i (rd_addr),
      .rdata_o (bank_rd[b])
    );
  end

  // ---------------- reader ----------------
  cpwin_reader #(.SYM_LEN(SYM_LEN), .CP_LEN(CP_LEN), .OVL_LEN(OVL_LEN)) u_reader (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .full_i      (full_q),
    .byp_i       (byp_q),
    .rd_en_o     (rd_en),
    .rd_sel_o    (rd_sel),
    .rd_addr_o   (rd_addr),
    .done_o      (rd_done),
    .blend_o     (rd_blend),
    .blend_idx_o (rd_bidx),
    .cap_o       (rd_cap),
    .cap_idx_o   (rd_cidx),
    .clr_o       (rd_clr)
  );

  // ---------------- read-data stage ----------------
  logic          s1_valid, s1_sel, s1_blend, s1_cap, s1_clr;
  logic [OW-1:0] s1_bidx, s1_cidx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_sel   <= 1'b0;
      s1_blend <= 1'b0;
      s1_cap   <= 1'b0;
      s1_clr   <= 1'b0;
      s1_bidx  <= '0;
      s1_cidx  <= '0;
    end else begin
      s1_valid <= rd_en;
      s1_sel   <= rd_sel;
      s1_blend <= rd_blend;
      s1_cap   <= rd_cap;
      s1_clr   <= rd_clr;
      s1_bidx  <= rd_bidx;
      s1_cidx  <= rd_cidx;
    end
  end

  logic signed [DW-1:0] s1_comp [2];
  logic signed [DW-1:0] tail_q  [2][OVL_LEN];
  logic signed [DW-1:0] tap_y   [2];

  always_comb begin
    s1_comp[0] = bank_rd[s1_sel][SW-1:DW];
    s1_comp[1] = bank_rd[s1_sel][DW-1:0];
  end

  // tail cache: last OVL_LEN body samples of a data symbol, cleared by bypass
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < 2; c++)
        for (int k = 0; k < OVL_LEN; k++) tail_q[c][k] <= '0;
    end else if (s1_valid && s1_clr) begin
      for (int c = 0; c < 2; c++)
        for (int k = 0; k < OVL_LEN; k++) tail_q[c][k] <= '0;
    end else if (s1_valid && s1_cap) begin
      for (int c = 0; c < 2; c++) tail_q[c][s1_cidx] <= s1_comp[c];
    end
  end

  for (genvar c = 0; c < 2; c++) begin : g_taper
    cpwin_taper #(.DW(DW), .OVL_LEN(OVL_LEN)) u_taper (
      .x_i   (s1_comp[c]),
      .t_i   (tail_q[c][s1_bidx]),
      .en_i  (s1_blend),
      .idx_i (s1_bidx),
      .y_o   (tap_y[c])
    );
  end

  // ---------------- output register ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_re_o    <= '0;
      out_im_o    <= '0;
    end else begin
      out_valid_o <= s1_valid;
      if (s1_valid) begin
        out_re_o <= tap_y[0];
        out_im_o <= tap_y[1];
      end
    end
  end

  // R9: writer never targets the bank under read
  p_no_clobber_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && rd_en) |-> (wr_sel_q != rd_sel));

  // R9: fixed two-stage path from read issue to output
  p_out_lat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en |-> ##2 out_valid_o);

  // R4: blending a sample with an equal cached value leaves it unchanged
  p_unity_gain_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid && s1_blend && s1_comp[0] == tail_q[0][s1_bidx])
      |=> (out_re_o == $past(s1_comp[0])));

endmodule

// File: tb/cpwin_inserter_bench.sv
`timescale 1ns/1ps
module cpwin_inserter_bench;

  localparam int SYM = 256;
  localparam int CP  = 16;
  localparam int OVL = 4;
  localparam int MAXN = 8192;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_byp = 1'b0;
  logic [15:0] in_re = '0;
  logic [15:0] in_im = '0;
  logic        out_valid;
  logic [15:0] out_re, out_im;

  always #2 clk = ~clk;

  cpwin_inserter u_cpwin_inserter (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid),
    .in_bypass_i (in_byp),
    .in_re_i     (in_re),
    .in_im_i     (in_im),
    .out_valid_o (out_valid),
    .out_re_o    (out_re),
    .out_im_o    (out_im)
  );

  int checks = 0, errors = 0, cyc = 0;
  int got_re [MAXN], got_im [MAXN], got_cyc [MAXN];
  int got_n = 0;
  int exp_re [MAXN], exp_im [MAXN];
  int exp_n = 0;
  int sym_re [SYM], sym_im [SYM];
  int tail_re [OVL], tail_im [OVL];

  always @(negedge clk) begin
    cyc++;
    if (out_valid && got_n < MAXN) begin
      got_re[got_n]  = int'($signed(out_re));
      got_im[got_n]  = int'($signed(out_im));
      got_cyc[got_n] = cyc;
      got_n++;
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R3 watchdog cycles %0d expected below %0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic fill(input int kind, input int seed);
    for (int n = 0; n < SYM; n++) begin
      case (kind)
        0: begin
          sym_re[n] = ((seed * 911 + n * 37) % 20000) - 10000;
          sym_im[n] = 5000 - ((seed * 53 + n * 101) % 10000);
        end
        1: begin sym_re[n] = -32768; sym_im[n] = 32767; end
        2: begin sym_re[n] = 32767;  sym_im[n] = -32768; end
        default: begin
          sym_re[n] = (n % 2 == 0) ? 30001 : -30001;
          sym_im[n] = -sym_re[n];
        end
      endcase
    end
  endtask

  function automatic int blend(input int x, input int t, input int k);
    longint r, a;
    r = longint'((k + 1) * 32768 / OVL);
    a = longint'(x) * r + longint'(t) * (64'sd32768 - r);
    return int'(a >>> 15);
  endfunction

  task automatic push_exp(input int re, input int im);
    exp_re[exp_n] = re;
    exp_im[exp_n] = im;
    exp_n++;
  endtask

  task automatic model(input bit byp);
    if (byp) begin
      for (int n = 0; n < SYM; n++) push_exp(sym_re[n], sym_im[n]);
      for (int j = 0; j < OVL; j++) begin tail_re[j] = 0; tail_im[j] = 0; end
    end else begin
      for (int k = 0; k < CP; k++) begin
        int xr, xi;
        xr = sym_re[SYM - CP + k];
        xi = sym_im[SYM - CP + k];
        if (k < OVL) begin
          xr = blend(xr, tail_re[k], k);
          xi = blend(xi, tail_im[k], k);
        end
        push_exp(xr, xi);
      end
      for (int n = 0; n < SYM; n++) push_exp(sym_re[n], sym_im[n]);
      for (int j = 0; j < OVL; j++) begin
        tail_re[j] = sym_re[SYM - OVL + j];
        tail_im[j] = sym_im[SYM - OVL + j];
      end
    end
  endtask

  task automatic send(input bit byp, input bit gappy, input bit wiggle);
    for (int n = 0; n < SYM; n++) begin
      if (gappy) begin
        in_valid = 1'b0;
        in_byp   = ~byp;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_re    = 16'(sym_re[n]);
      in_im    = 16'(sym_im[n]);
      in_byp   = (n == 0) ? byp : (wiggle ? ~byp : byp);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_byp   = 1'b0;
  endtask

  task automatic check_sym(input string tag, input int base, input int len);
    int guard = 0, bad = -1;
    while (got_n < base + len && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    checks++;
    if (got_n < base + len) begin
      errors++;
      $display("FAIL %s output count got %0d expected %0d", tag, got_n - base, len);
      return;
    end
    for (int i = 0; i < len; i++)
      if (bad < 0 && (got_re[base+i] != exp_re[base+i] || got_im[base+i] != exp_im[base+i]))
        bad = i;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s sample %0d got %0d/%0d expected %0d/%0d", tag, bad,
               got_re[base+bad], got_im[base+bad], exp_re[base+bad], exp_im[base+bad]);
    end
    checks++;
    if (got_cyc[base+len-1] - got_cyc[base] != len - 1) begin
      errors++;
      $display("FAIL R3 span got %0d expected %0d", got_cyc[base+len-1] - got_cyc[base], len - 1);
    end
  endtask

  task automatic run_sym(input string tag, input int kind, input int seed,
                         input bit byp, input bit gappy, input bit wiggle);
    int base;
    base = exp_n;
    fill(kind, seed);
    model(byp);
    send(byp, gappy, wiggle);
    repeat (40) @(negedge clk);
    check_sym(tag, base, byp ? SYM : SYM + CP);
  endtask

  // R1: quiet outputs after reset, nothing without a full symbol
  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_re !== 16'h0 || out_im !== 16'h0) begin
      errors++;
      $display("FAIL R1 reset outputs got %b/%h/%h expected 0/0000/0000", out_valid, out_re, out_im);
    end
    repeat (20) @(negedge clk);
    checks++;
    if (got_n != 0) begin
      errors++;
      $display("FAIL R1 idle outputs got %0d expected 0", got_n);
    end
  endtask

  // R2 R5 R9: first data symbol, latency and zero-tail blend
  task automatic t_first;
    int base;
    base = exp_n;
    fill(0, 1);
    model(1'b0);
    send(1'b0, 1'b0, 1'b0);
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R9 valid after second edge got %b expected 0", out_valid);
    end
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b1) begin
      errors++;
      $display("FAIL R9 valid after third edge got %b expected 1", out_valid);
    end
    repeat (40) @(negedge clk);
    check_sym("R2 R5", base, SYM + CP);
  endtask

  // R4: blend against a cached tail, typical and full-scale values
  task automatic t_taper;
    run_sym("R4", 0, 2, 1'b0, 1'b0, 1'b0);
    run_sym("R4", 1, 0, 1'b0, 1'b0, 1'b0);
    run_sym("R4", 2, 0, 1'b0, 1'b0, 1'b0);
    run_sym("R4", 3, 0, 1'b0, 1'b0, 1'b0);
  endtask

  // R6 R5: bypass passes through, next data blends against zero
  task automatic t_bypass;
    run_sym("R6", 0, 5, 1'b1, 1'b0, 1'b0);
    run_sym("R5", 0, 6, 1'b0, 1'b0, 1'b0);
  endtask

  // R7: mode changes after the first sample are ignored
  task automatic t_mode_hold;
    run_sym("R7", 0, 7, 1'b0, 1'b0, 1'b1);
    run_sym("R7", 0, 8, 1'b1, 1'b0, 1'b1);
  endtask

  // R8: sparse input
  task automatic t_gappy;
    run_sym("R8", 0, 9, 1'b0, 1'b0, 1'b0);
    run_sym("R8", 0, 12, 1'b0, 1'b1, 1'b0);
  endtask

  // R9: back-to-back symbols through both banks
  task automatic t_pingpong;
    int b1, b2;
    b1 = exp_n;
    fill(0, 10);
    model(1'b0);
    send(1'b0, 1'b0, 1'b0);
    b2 = exp_n;
    fill(3, 0);
    model(1'b0);
    send(1'b0, 1'b0, 1'b0);
    repeat (320) @(negedge clk);
    check_sym("R9", b1, SYM + CP);
    check_sym("R9", b2, SYM + CP);
    checks++;
    if (got_n > b2 && got_cyc[b2] - got_cyc[b2-1] != 2) begin
      errors++;
      $display("FAIL R9 inter-symbol gap got %0d expected %0d", got_cyc[b2] - got_cyc[b2-1], 2);
    end
  endtask

  initial begin
    for (int j = 0; j < OVL; j++) begin tail_re[j] = 0; tail_im[j] = 0; end
    t_reset;
    t_first;
    t_taper;
    t_bypass;
    t_mode_hold;
    t_gappy;
    t_pingpong;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule